// File: doc/BRIEF.md
# Register Write-Enable and Status Controller

This block sits behind the byte-level engine of a two-wire serial slave that fronts a clock/calendar register file and a nonvolatile memory array. For every host transaction it receives a start strobe with the target address and space (register space or memory array), then a stream of write-byte or read-byte strobes, and finally a valid stop. It holds the volatile status byte. It enforces a two-step unlock before register or memory contents may change, and it decides for each written byte whether it is acknowledged or silently ignored. It also steps the address pointer so that sequential access stays inside one register section.

Two enable latches guard writes. The first, the write latch, must be set before any memory or register byte is accepted. The second, the register latch, can only be set while the write latch is already set, and it is needed in addition for every register write other than the status byte. Status writes take effect at the stop. When a transaction has accepted at least one byte for a register or memory location, a one-cycle commit pulse follows its stop. The pulse tells the storage side to copy its buffered data. Hardware inputs report battery operation, the two alarm matches and a total power-loss event. These appear in the status byte.

Top module: `rtc_wprot_ctrl`

## Requirements
- R1: After reset the status byte is 00h, and the acknowledge, commit and terminate outputs are 0.
- R2: The status byte is {battery, alarm1, alarm0, 0, 0, register latch, write latch, clock-fail}, bit 7 first. Bits 7..5 follow their hardware inputs with one cycle of delay and cannot be changed by host writes.
- R3: A status write of exactly 02h, completed by a stop, sets the write latch. A status write of 00h clears both latches.
- R4: A status write of exactly 06h sets the register latch, but only when the write latch is already 1. Any other nonzero value leaves both latches unchanged.
- R5: While the write latch is 0, a byte written to any register other than status (address 3Fh), or to the memory array, is not acknowledged, does not move the pointer and produces no commit.
- R6: A register-space write to any address other than 3Fh is acknowledged only when both latches are 1. A write to an unmapped register address is never acknowledged. A memory write needs only the write latch. A status write needs neither latch and produces no commit.
- R7: Commit pulses for one cycle, in the cycle after a stop, when that transaction acknowledged at least one non-status byte.
- R8: The power-fail event sets the clock-fail bit. A stop that ends a transaction which accepted a write to the time section (30h..37h) clears it. A power-fail event in the same cycle takes priority.
- R9: The sections are alarm A at 00h..07h, alarm B at 08h..0Fh, control at 10h..11h and time at 30h..37h. Each acknowledged write or read advances the pointer and wraps to the section's first address at its end.
- R10: The status section (3Fh) takes one byte. A second read or write byte in the same transaction raises terminate, is not acknowledged, and leaves the pointer at 3Fh. Any pending status write is then discarded.
- R11: In the memory array the pointer counts through the whole address width and wraps from the top address to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transaction start, loads the address |
| addr_i | input | MEM_AW | Start address |
| ccr_i | input | 1 | 1 selects register space, 0 the memory array |
| wr_i | input | 1 | Write data byte strobe |
| rd_i | input | 1 | Read data byte strobe |
| data_i | input | 8 | Write data byte |
| stop_i | input | 1 | Valid stop, ends the transaction |
| bat_i | input | 1 | Running from the backup supply |
| alarm1_i | input | 1 | Alarm B match flag |
| alarm0_i | input | 1 | Alarm A match flag |
| pwr_fail_i | input | 1 | Total power-loss event pulse |
| status_o | output | 8 | Status byte |
| ack_o | output | 1 | Previous write byte acknowledged |
| commit_o | output | 1 | Copy buffered data to storage |
| ptr_o | output | MEM_AW | Current address pointer |
| term_o | output | 1 | Transaction terminated by continued status access |

## Verification
The assertions assume that start, a byte strobe and stop never come in the same cycle. They also assume that a byte strobe comes only between a start and its stop, and that a byte strobe is not followed by another strobe in the very next cycle. The bench keeps to these assumptions by driving exactly one strobe per two-cycle slot from tasks, always on the falling edge. The status-write table walks the latch pair through legal, premature and malformed unlock values. Directed tests then cover section wrap, the status-section terminate, memory-top wrap and the same-cycle power-fail priority.

// File: rtl/rtc_wp_pkg.sv
package rtc_wp_pkg;
  localparam int CCR_AW   = 6;
  localparam logic [CCR_AW-1:0] STAT_ADDR = 6'h3F;
  localparam logic [7:0] PAT_WEL  = 8'h02;
  localparam logic [7:0] PAT_RWEL = 8'h06;

  typedef enum logic [2:0] {
    SEC_ALM0, SEC_ALM1, SEC_CTRL, SEC_CLK, SEC_STAT, SEC_NONE
  } sec_e;

  function automatic sec_e sec_of(input logic [CCR_AW-1:0] a);
    if (a == STAT_ADDR)              return SEC_STAT;
    else if (a[5:3] == 3'b000)       return SEC_ALM0;
    else if (a[5:3] == 3'b001)       return SEC_ALM1;
    else if (a[5:1] == 5'b01000)     return SEC_CTRL;
    else if (a[5:3] == 3'b110)       return SEC_CLK;
    else                             return SEC_NONE;
  endfunction

  function automatic logic [CCR_AW-1:0] ccr_next(input logic [CCR_AW-1:0] a);
    case (sec_of(a))
      SEC_ALM0, SEC_ALM1, SEC_CLK: return {a[5:3], a[2:0] + 3'd1};
      SEC_CTRL:                    return {a[5:1], ~a[0]};
      SEC_STAT:                    return a;
      default:                     return a + 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/rtc_wp_addr.sv
module rtc_wp_addr
  import rtc_wp_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [MEM_AW-1:0] load_addr_i,
  input  logic              load_ccr_i,
  input  logic              adv_i,
  output logic [MEM_AW-1:0] ptr_o,
  output logic              ccr_o,
  output sec_e              sec_o
);
  localparam int PAD = MEM_AW - CCR_AW;

  logic [MEM_AW-1:0] ptr_q, ptr_d;
  logic              ccr_q, ccr_d;
  logic              en;

  always_comb begin
    ptr_d = ptr_q;
    ccr_d = ccr_q;
    en    = load_i | adv_i;
    if (load_i) begin
      ccr_d = load_ccr_i;
      ptr_d = load_ccr_i ? {{PAD{1'b0}}, load_addr_i[CCR_AW-1:0]} : load_addr_i;
    end else if (adv_i) begin
      ptr_d = ccr_q ? {{PAD{1'b0}}, ccr_next(ptr_q[CCR_AW-1:0])} : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      ccr_q <= 1'b0;
    end else if (en) begin
      ptr_q <= ptr_d;
      ccr_q <= ccr_d;
    end
  end

  assign ptr_o = ptr_q;
  assign ccr_o = ccr_q;
  assign sec_o = sec_of(ptr_q[CCR_AW-1:0]);

  AST_CLK_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && ccr_o && sec_o == SEC_CLK) |=> (sec_o == SEC_CLK)); // R9
  AST_STAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && ccr_o && sec_o == SEC_STAT) |=> $stable(ptr_o)); // R10
endmodule

// File: rtl/rtc_wp_latch.sv
module rtc_wp_latch (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_i,
  input  logic [7:0] data_i,
  input  logic       pwr_fail_i,
  input  logic       rtcf_clr_i,
  input  logic       bat_i,
  input  logic       al1_i,
  input  logic       al0_i,
  output logic [7:0] status_o,
  output logic       wel_o,
  output logic       rwel_o
);
  import rtc_wp_pkg::*;

  logic wel_q, wel_d, rwel_q, rwel_d, rtcf_q, rtcf_d;
  logic [2:0] hw_q;

  always_comb begin
    wel_d  = wel_q;
    rwel_d = rwel_q;
    if (upd_i) begin
      if (data_i == 8'h00) begin
        wel_d  = 1'b0;
        rwel_d = 1'b0;
      end else if (data_i == PAT_WEL) begin
        wel_d  = 1'b1;
      end else if (data_i == PAT_RWEL && wel_q) begin
        rwel_d = 1'b1;
      end
    end
    if (pwr_fail_i)      rtcf_d = 1'b1;
    else if (rtcf_clr_i) rtcf_d = 1'b0;
    else                 rtcf_d = rtcf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q  <= 1'b0;
      rwel_q <= 1'b0;
      rtcf_q <= 1'b0;
      hw_q   <= 3'b000;
    end else begin
      if (upd_i) begin
        wel_q  <= wel_d;
        rwel_q <= rwel_d;
      end
      rtcf_q <= rtcf_d;
      hw_q   <= {bat_i, al1_i, al0_i};
    end
  end

  assign status_o = {hw_q, 2'b00, rwel_q, wel_q, rtcf_q};
  assign wel_o    = wel_q;
  assign rwel_o   = rwel_q;

  AST_RWEL_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
    rwel_q |-> wel_q); // R4
  AST_PFAIL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail_i |=> status_o[0]); // R8
endmodule

// File: rtl/rtc_wp_gate.sv
module rtc_wp_gate
  import rtc_wp_pkg::*;
(
  input  logic wr_i,
  input  logic rd_i,
  input  logic live_i,
  input  logic term_i,
  input  logic seen_i,
  input  logic ccr_i,
  input  sec_e sec_i,
  input  logic wel_i,
  input  logic rwel_i,
  output logic wr_ok_o,
  output logic stat_wr_o,
  output logic adv_o,
  output logic kill_o
);
  logic is_stat;

  always_comb begin
    wr_ok_o   = 1'b0;
    stat_wr_o = 1'b0;
    adv_o     = 1'b0;
    kill_o    = 1'b0;
    is_stat   = ccr_i && (sec_i == SEC_STAT);
    if (live_i && !term_i) begin
      if (wr_i) begin
        if (is_stat) begin
          if (seen_i) kill_o = 1'b1;
          else begin
            wr_ok_o   = 1'b1;
            stat_wr_o = 1'b1;
          end
        end else if (wel_i) begin
          if (!ccr_i) begin
            wr_ok_o = 1'b1;
            adv_o   = 1'b1;
          end else if (rwel_i && sec_i != SEC_NONE) begin
            wr_ok_o = 1'b1;
            adv_o   = 1'b1;
          end
        end
      end else if (rd_i) begin
        if (is_stat) kill_o = seen_i;
        else         adv_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rtc_wprot_ctrl.sv
module rtc_wprot_ctrl
  import rtc_wp_pkg::*;
#(
  parameter int MEM_AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [MEM_AW-1:0] addr_i,
  input  logic              ccr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [7:0]        data_i,
  input  logic              stop_i,
  input  logic              bat_i,
  input  logic              alarm1_i,
  input  logic              alarm0_i,
  input  logic              pwr_fail_i,
  output logic [7:0]        status_o,
  output logic              ack_o,
  output logic              commit_o,
  output logic [MEM_AW-1:0] ptr_o,
  output logic              term_o
);
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  logic live_q, live_d, term_q, term_d, seen_q, seen_d;
  logic pend_q, pend_d, wany_q, wany_d, chit_q, chit_d;
  logic ack_q, ack_d, commit_q, commit_d;
  logic [7:0] pdat_q, pdat_d;
  logic upd, rclr, adv_raw, adv, wr_ok, stat_wr, kill, wel, rwel, ccr_cur;
  sec_e sec_cur;

  rtc_wp_addr #(.MEM_AW(MEM_AW)) u_addr (
    .clk(clk), .rst_n(rst_s_n), .load_i(start_i), .load_addr_i(addr_i),
    .load_ccr_i(ccr_i), .adv_i(adv), .ptr_o(ptr_o), .ccr_o(ccr_cur), .sec_o(sec_cur)
  );

  rtc_wp_gate u_gate (
    .wr_i(wr_i), .rd_i(rd_i), .live_i(live_q), .term_i(term_q), .seen_i(seen_q),
    .ccr_i(ccr_cur), .sec_i(sec_cur), .wel_i(wel), .rwel_i(rwel),
    .wr_ok_o(wr_ok), .stat_wr_o(stat_wr), .adv_o(adv_raw), .kill_o(kill)
  );

  rtc_wp_latch u_latch (
    .clk(clk), .rst_n(rst_s_n), .upd_i(upd), .data_i(pdat_q), .pwr_fail_i(pwr_fail_i),
    .rtcf_clr_i(rclr), .bat_i(bat_i), .al1_i(alarm1_i), .al0_i(alarm0_i),
    .status_o(status_o), .wel_o(wel), .rwel_o(rwel)
  );

  assign adv = adv_raw && !start_i && !stop_i;

  always_comb begin
    live_d = live_q; term_d = term_q; seen_d = seen_q; pend_d = pend_q;
    pdat_d = pdat_q; wany_d = wany_q; chit_d = chit_q;
    ack_d = 1'b0; commit_d = 1'b0; upd = 1'b0; rclr = 1'b0;
    if (start_i) begin
      live_d = 1'b1; term_d = 1'b0; seen_d = 1'b0;
      pend_d = 1'b0; wany_d = 1'b0; chit_d = 1'b0;
    end else if (stop_i && live_q) begin
      live_d = 1'b0; term_d = 1'b0;
      upd = pend_q; commit_d = wany_q; rclr = chit_q;
      pend_d = 1'b0; wany_d = 1'b0; chit_d = 1'b0;
    end else if (kill) begin
      term_d = 1'b1; pend_d = 1'b0; wany_d = 1'b0; chit_d = 1'b0;
    end else begin
      if (wr_ok) begin
        ack_d  = 1'b1;
        seen_d = 1'b1;
        if (stat_wr) begin
          pend_d = 1'b1;
          pdat_d = data_i;
        end else begin
          wany_d = 1'b1;
          if (ccr_cur && sec_cur == SEC_CLK) chit_d = 1'b1;
        end
      end
      if (rd_i && live_q && !term_q) seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      live_q <= 1'b0; term_q <= 1'b0; seen_q <= 1'b0; pend_q <= 1'b0;
      pdat_q <= 8'h00; wany_q <= 1'b0; chit_q <= 1'b0;
      ack_q  <= 1'b0; commit_q <= 1'b0;
    end else begin
      live_q <= live_d; term_q <= term_d; seen_q <= seen_d; pend_q <= pend_d;
      pdat_q <= pdat_d; wany_q <= wany_d; chit_q <= chit_d;
      ack_q  <= ack_d;  commit_q <= commit_d;
    end
  end

  assign ack_o    = ack_q;
  assign commit_o = commit_q;
  assign term_o   = term_q;

  AST_LOCKED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_s_n)
    (wr_i && !wel && !(ccr_cur && sec_cur == SEC_STAT)) |=> !ack_o); // R5
  AST_COMMIT_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_s_n)
    commit_o |-> $past(stop_i)); // R7
  AST_TERM_QUIET: assert property (@(posedge clk) disable iff (!rst_s_n)
    (term_o && $past(term_o)) |-> !ack_o); // R10
endmodule

// File: tb/rtc_wprot_ctrl_test.sv
module rtc_wprot_ctrl_test;
  localparam int AW = 11;
  logic clk = 1'b0;
  logic rst_n;
  logic start_i, ccr_i, wr_i, rd_i, stop_i, bat_i, alarm1_i, alarm0_i, pwr_fail_i;
  logic [AW-1:0] addr_i;
  logic [7:0] data_i;
  logic [7:0] status_o;
  logic ack_o, commit_o, term_o;
  logic [AW-1:0] ptr_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_wprot_ctrl #(.MEM_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .ccr_i(ccr_i),
    .wr_i(wr_i), .rd_i(rd_i), .data_i(data_i), .stop_i(stop_i), .bat_i(bat_i),
    .alarm1_i(alarm1_i), .alarm0_i(alarm0_i), .pwr_fail_i(pwr_fail_i),
    .status_o(status_o), .ack_o(ack_o), .commit_o(commit_o), .ptr_o(ptr_o), .term_o(term_o)
  );

  // status write value in [15:8], expected status byte after stop in [7:0]
  localparam logic [15:0] TBL [9] = '{
    16'h06_00, 16'h04_00, 16'h02_02, 16'h04_02, 16'h06_06,
    16'h02_06, 16'h03_06, 16'h00_00, 16'h06_00
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic op_start(input int a, input bit c);
    @(negedge clk); start_i = 1; addr_i = AW'(a); ccr_i = c;
    @(negedge clk); start_i = 0;
  endtask
  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk); wr_i = 1; data_i = d;
    @(negedge clk); wr_i = 0;
  endtask
  task automatic rd_byte();
    @(negedge clk); rd_i = 1;
    @(negedge clk); rd_i = 0;
  endtask
  task automatic op_stop(input bit pf);
    @(negedge clk); stop_i = 1; pwr_fail_i = pf;
    @(negedge clk); stop_i = 0; pwr_fail_i = 0;
  endtask
  task automatic stat_wr(input logic [7:0] d);
    op_start(8'h3F, 1); wr_byte(d); op_stop(0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; start_i = 0; ccr_i = 0; wr_i = 0; rd_i = 0; stop_i = 0;
    bat_i = 0; alarm1_i = 0; alarm0_i = 0; pwr_fail_i = 0; addr_i = '0; data_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 status", status_o, 8'h00);
    chk("R1 ack/commit/term", {ack_o, commit_o, term_o}, 0);

    for (int i = 0; i < 9; i++) begin
      stat_wr(TBL[i][15:8]);
      chk((TBL[i][15:8] == 8'h06) ? "R4 table" : "R3 table", status_o, TBL[i][7:0]);
    end

    // locked: memory write ignored
    op_start(5, 0); wr_byte(8'hAA);
    chk("R5 ack", ack_o, 0); chk("R5 ptr", ptr_o, 5);
    op_stop(0); chk("R5 commit", commit_o, 0);

    stat_wr(8'h02); chk("R6 status write no commit", commit_o, 0);
    op_start(8'h07, 1); wr_byte(8'h11); chk("R6 reg needs rwel", ack_o, 0); op_stop(0);
    op_start(5, 0); wr_byte(8'h11);
    chk("R6 mem ack", ack_o, 1); chk("R11 ptr", ptr_o, 6);
    op_stop(0); chk("R7 commit", commit_o, 1);

    stat_wr(8'h06); chk("R4 unlock", status_o, 8'h06);
    op_start(8'h07, 1); wr_byte(8'h01);
    chk("R6 reg ack", ack_o, 1); chk("R9 alarm A wrap", ptr_o, 8'h00);
    wr_byte(8'h02); chk("R9 advance", ptr_o, 8'h01);
    op_stop(0); chk("R7 commit reg", commit_o, 1);
    op_start(8'h0F, 1); wr_byte(8'h03); chk("R9 alarm B wrap", ptr_o, 8'h08); op_stop(0);
    op_start(8'h11, 1); wr_byte(8'h04); chk("R9 control wrap", ptr_o, 8'h10); op_stop(0);
    op_start(8'h37, 1); rd_byte(); chk("R9 read wrap", ptr_o, 8'h30);
    op_stop(0); chk("R7 read no commit", commit_o, 0);
    op_start(8'h20, 1); wr_byte(8'h05); chk("R6 unmapped", ack_o, 0); op_stop(0);

    // clock-fail bit
    @(negedge clk); pwr_fail_i = 1; @(negedge clk); pwr_fail_i = 0;
    chk("R8 set", status_o[0], 1);
    op_start(8'h02, 1); wr_byte(8'h09); op_stop(0); chk("R8 alarm write keeps", status_o[0], 1);
    op_start(8'h32, 1); wr_byte(8'h09); op_stop(0); chk("R8 clear", status_o[0], 0);
    op_start(8'h33, 1); wr_byte(8'h09); op_stop(1); chk("R8 priority", status_o[0], 1);
    op_start(8'h30, 1); wr_byte(8'h00); op_stop(0); chk("R8 clear again", status_o[0], 0);

    // hardware bits
    @(negedge clk); bat_i = 1; alarm0_i = 1;
    @(negedge clk); chk("R2 hw bits", status_o, 8'hA6);
    stat_wr(8'hE2); chk("R2 read-only", status_o, 8'hA6);
    chk("R4 odd pattern", status_o[2:1], 2'b11);
    @(negedge clk); bat_i = 0; alarm0_i = 0; alarm1_i = 1;
    @(negedge clk); chk("R2 alarm1", status_o, 8'h46);
    alarm1_i = 0;

    // status section single byte
    op_start(8'h3F, 1); wr_byte(8'h00); chk("R10 first ack", ack_o, 1);
    wr_byte(8'h00);
    chk("R10 second no ack", ack_o, 0); chk("R10 term", term_o, 1); chk("R10 ptr", ptr_o, 8'h3F);
    op_stop(0); chk("R10 discarded", status_o[2:1], 2'b11);
    op_start(8'h3F, 1); rd_byte(); chk("R10 first read", term_o, 0);
    rd_byte(); chk("R10 read term", term_o, 1); op_stop(0);

    // memory top wrap
    op_start(11'h7FF, 0); wr_byte(8'h5A); chk("R11 wrap", ptr_o, 0); op_stop(0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule